// File: doc/BRIEF.md
# Compare-Match PWM Timer Channel

This block holds a small group of 16-bit counting channels behind one register port. Each channel counts prescaled clock edges and drives one pulse-width-modulated pin. The period is set by a second compare register that can clear the counter when it matches. The duty cycle is set by a first compare register: the pin is low from the start of a period until the counter reaches the first compare value, then high until the second compare value ends the period. Channels are started and stopped by their own bit in a run-enable register that all channels share.

Software picks a clock divide of 1, 4, 16 or 64. It writes the two compare values, selects clear-on-second-compare, selects the PWM mode and the low-then-high output pattern, and then sets the channel's run bit. Compare registers may be rewritten at any time. They are only sampled on count edges, so a new value takes effect at the next count edge. Each channel is a four-state machine whose state carries the pin level and whether the channel is counting. HOLD_LO and HOLD_HI are the stopped states: the counter is frozen and the pin keeps its level. RUN_LO and RUN_HI are the counting states. The transitions are:
- START: a HOLD state moves to the RUN state of the same level when the run bit is set. The first count edge is applied in the same step.
- STOP: a RUN state moves back to the HOLD state of the same level when the run bit clears.
- RISE: RUN_LO moves to RUN_HI on a count edge in PWM mode when the new counter value falls inside the high window.
- FALL: RUN_HI moves to RUN_LO on a count edge in PWM mode when the new counter value falls outside the high window.

Top module: `tpu_pwm_unit`

## Requirements
- R1: After synchronous reset, every register reads 0, every counter is 0 and every pin is low.
- R2: The run-enable register sits at address 0x00. Bit i starts channel i when set and stops it when clear, and the register reads back. Channel i owns a 64-byte window at 0x40*(i+1). Channels run independently of each other.
- R3: Control bits [1:0] = 0, 1, 2, 3 make the counter advance once every 1, 4, 16 or 64 clocks. The first count edge is the divide-th clock edge after the edge that latched the run bit. No count edge occurs while the channel is stopped.
- R4: On each count edge the counter increments and wraps from 0xFFFF to 0. When control bit 6 is set (control value 0x0040), the counter instead goes to 0 on the edge where it equals compare B (offset 0x1C).
- R5: When the mode register (offset 0x04) has low nibble 2 and the output register (offset 0x08) has low nibble 2, the pin is updated after each count edge. It is high when A < B and A <= new count <= B, and low otherwise. Compare A is at offset 0x18.
- R6: With clear-on-B, A = 0 gives a pin that stays high, and A >= B gives a pin that stays low.
- R7: While a channel is stopped, its counter and pin hold. Its registers remain writable and readable.
- R8: The status register (offset 0x10) sets bit 0 on a count edge where the counter equals A, and bit 1 on one where it equals B. Writing 1 to a bit clears it, but a set in the same cycle wins.
- R9: The compare registers are only sampled on count edges, so a write between edges takes effect at the next count edge.
- R10: Control 0x00, mode 0x04, output 0x08, interrupt-enable 0x0C, counter 0x14 and general registers 0x18, 0x1C, 0x20, 0x24 read back what was written. A counter write overrides a count in the same cycle. Offsets above 0x24, other offsets of the run-enable window and windows beyond the last channel read 0.
- R11: Outside PWM mode the counter still runs but the pin holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pwm_out | output | NUM_CH | One PWM pin per channel |

## Verification
The assertions assume that bus_addr, bus_wdata and bus_we are always known values and that each write lasts one clock. They also assume the run-enable register changes only through a write to address 0x00, which lets a pin change be traced back to a count edge of a running channel. The stimulus changes all bus inputs only on the falling clock edge, holds the write strobe for exactly one cycle and leaves the address on a defined register between accesses. A cycle-based model in the bench predicts every pin on every clock and every readback.

// File: rtl/tpu_pwm_pkg.sv
package tpu_pwm_pkg;
    localparam int REG_W = 16;

    // channel register offsets within a channel window
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_MODE = 'h04;
    localparam int OFS_IOC  = 'h08;
    localparam int OFS_IEN  = 'h0C;
    localparam int OFS_STAT = 'h10;
    localparam int OFS_CNT  = 'h14;
    localparam int OFS_GRA  = 'h18;
    localparam int NUM_GR   = 4;
    localparam int OFS_LAST = OFS_GRA + 4 * (NUM_GR - 1);

    localparam int CLR_B_BIT  = 6;
    localparam logic [3:0] MODE_PWM  = 4'h2;
    localparam logic [3:0] IOC_LO_HI = 4'h2;

    typedef enum logic [1:0] {
        ST_HOLD_LO,
        ST_HOLD_HI,
        ST_RUN_LO,
        ST_RUN_HI
    } chan_state_t;
endpackage

// File: rtl/tpu_prescaler.sv
module tpu_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = 2 * ((1 << SEL_W) - 1);

    logic [CNT_W-1:0] div_cnt;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim  = CNT_W'((32'd1 << (2 * sel)) - 32'd1);
        tick = run && (div_cnt >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tpu_pwm_chan.sv
module tpu_pwm_chan
    import tpu_pwm_pkg::*;
#(
    parameter int OFS_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] ofs,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [1:0]       div_sel,
    output logic             pin
);
    logic [REG_W-1:0] ctrl_q, mode_q, ioc_q, ien_q, cnt_q;
    logic [1:0]       stat_q;
    logic [REG_W-1:0] gr_q [NUM_GR];

    chan_state_t state_q, state_d;

    logic hit_a, hit_b, pwm_en, level_nxt, to_hi, to_lo;
    logic [REG_W-1:0] cnt_nxt;
    logic [1:0] stat_set, stat_clr;

    // plain control registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mode_q <= '0;
            ioc_q  <= '0;
            ien_q  <= '0;
        end else if (wr_en) begin
            if (ofs == OFS_W'(OFS_CTRL)) ctrl_q <= wdata;
            if (ofs == OFS_W'(OFS_MODE)) mode_q <= wdata;
            if (ofs == OFS_W'(OFS_IOC))  ioc_q  <= wdata;
            if (ofs == OFS_W'(OFS_IEN))  ien_q  <= wdata;
        end
    end

    // general compare registers
    for (genvar g = 0; g < NUM_GR; g++) begin : g_gr
        always_ff @(posedge clk) begin
            if (rst) begin
                gr_q[g] <= '0;
            end else if (wr_en && (ofs == OFS_W'(OFS_GRA + 4 * g))) begin
                gr_q[g] <= wdata;
            end
        end
    end

    // counter next value and match detection
    always_comb begin
        hit_a     = (cnt_q == gr_q[0]);
        hit_b     = (cnt_q == gr_q[1]);
        cnt_nxt   = (ctrl_q[CLR_B_BIT] && hit_b) ? '0 : cnt_q + 1'b1;
        pwm_en    = (mode_q[3:0] == MODE_PWM) && (ioc_q[3:0] == IOC_LO_HI);
        level_nxt = (gr_q[0] < gr_q[1]) && (cnt_nxt >= gr_q[0]) && (cnt_nxt <= gr_q[1]);
        to_hi     = tick && pwm_en && level_nxt;
        to_lo     = tick && pwm_en && !level_nxt;
        stat_set  = tick ? {hit_b, hit_a} : 2'b00;
        stat_clr  = (wr_en && (ofs == OFS_W'(OFS_STAT))) ? wdata[1:0] : 2'b00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_en && (ofs == OFS_W'(OFS_CNT))) begin
            cnt_q <= wdata;
        end else if (tick) begin
            cnt_q <= cnt_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~stat_clr) | stat_set;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: START, STOP, RISE, FALL
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD_LO: if (run) state_d = to_hi ? ST_RUN_HI : ST_RUN_LO;
            ST_HOLD_HI: if (run) state_d = to_lo ? ST_RUN_LO : ST_RUN_HI;
            ST_RUN_LO: begin
                if (!run)       state_d = ST_HOLD_LO;
                else if (to_hi) state_d = ST_RUN_HI;
            end
            ST_RUN_HI: begin
                if (!run)       state_d = ST_HOLD_HI;
                else if (to_lo) state_d = ST_RUN_LO;
            end
            default: state_d = ST_HOLD_LO;
        endcase
    end

    // outputs
    always_comb begin
        pin     = (state_q == ST_RUN_HI) || (state_q == ST_HOLD_HI);
        div_sel = ctrl_q[1:0];
        rdata   = '0;
        case (ofs)
            OFS_W'(OFS_CTRL): rdata = ctrl_q;
            OFS_W'(OFS_MODE): rdata = mode_q;
            OFS_W'(OFS_IOC):  rdata = ioc_q;
            OFS_W'(OFS_IEN):  rdata = ien_q;
            OFS_W'(OFS_STAT): rdata = {{(REG_W-2){1'b0}}, stat_q};
            OFS_W'(OFS_CNT):  rdata = cnt_q;
            default:          rdata = '0;
        endcase
        for (int g = 0; g < NUM_GR; g++) begin
            if (ofs == OFS_W'(OFS_GRA + 4 * g)) rdata = gr_q[g];
        end
    end
endmodule

// File: rtl/tpu_pwm_unit.sv
module tpu_pwm_unit
    import tpu_pwm_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter int ADDR_W  = 8,
    parameter int CH_SPAN = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int OFS_W = $clog2(CH_SPAN);
    localparam int BLK_W = ADDR_W - OFS_W;

    logic [BLK_W-1:0]  blk;
    logic [OFS_W-1:0]  ofs;
    logic [NUM_CH-1:0] start_q;
    logic [NUM_CH-1:0] tick;
    logic [NUM_CH-1:0] ch_we;
    logic [REG_W-1:0]  ch_rdata [NUM_CH];
    logic [1:0]        ch_sel   [NUM_CH];

    assign blk = bus_addr[ADDR_W-1:OFS_W];
    assign ofs = bus_addr[OFS_W-1:0];

    // shared run-enable register
    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
        end else if (bus_we && (blk == '0) && (ofs == '0)) begin
            start_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign ch_we[i] = bus_we && (blk == BLK_W'(i + 1));

        tpu_prescaler #(.SEL_W(2)) u_presc (
            .clk  (clk),
            .rst  (rst),
            .run  (start_q[i]),
            .sel  (ch_sel[i]),
            .tick (tick[i])
        );

        tpu_pwm_chan #(.OFS_W(OFS_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .run     (start_q[i]),
            .tick    (tick[i]),
            .wr_en   (ch_we[i]),
            .ofs     (ofs),
            .wdata   (bus_wdata),
            .rdata   (ch_rdata[i]),
            .div_sel (ch_sel[i]),
            .pin     (pwm_out[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if ((blk == '0) && (ofs == '0)) bus_rdata = REG_W'(start_q);
        for (int i = 0; i < NUM_CH; i++) begin
            if (blk == BLK_W'(i + 1)) bus_rdata = ch_rdata[i];
        end
    end
endmodule

// File: rtl/tpu_pwm_unit_chk.sv
module tpu_pwm_unit_chk
    import tpu_pwm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8,
    parameter int OFS_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NUM_CH-1:0] start_wdata,
    input logic [REG_W-1:0]  bus_rdata,
    input logic [NUM_CH-1:0] pwm_out,
    input logic [NUM_CH-1:0] start_q,
    input logic [NUM_CH-1:0] tick
);
    AST_START_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == '0)) |=> (start_q == $past(start_wdata))); // R2

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[OFS_W-1:0] > OFS_W'(OFS_LAST)) |-> (bus_rdata == '0)); // R10

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        AST_NO_TICK_HALTED: assert property (@(posedge clk) disable iff (rst)
            !start_q[i] |-> !tick[i]); // R3

        AST_HALT_PIN_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!start_q[i] && !$past(start_q[i])) |-> $stable(pwm_out[i])); // R7

        AST_PIN_ON_TICK: assert property (@(posedge clk) disable iff (rst)
            !$stable(pwm_out[i]) |-> $past(tick[i])); // R5
    end
endmodule

bind tpu_pwm_unit tpu_pwm_unit_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .start_wdata (bus_wdata[NUM_CH-1:0]),
    .bus_rdata   (bus_rdata),
    .pwm_out     (pwm_out),
    .start_q     (start_q),
    .tick        (tick)
);

// File: tb/tpu_pwm_unit_tb.sv
module tpu_pwm_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic [1:0]  pwm_out;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";

    tpu_pwm_unit u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int m_start;
    int m_ctrl[NCH], m_mode[NCH], m_ioc[NCH], m_ien[NCH], m_st[NCH];
    int m_cnt[NCH], m_pin[NCH], m_presc[NCH];
    int m_gr[NCH][4];

    always @(posedge clk) begin
        if (rst) begin
            m_start = 0;
            for (int c = 0; c < NCH; c++) begin
                m_ctrl[c] = 0; m_mode[c] = 0; m_ioc[c] = 0; m_ien[c] = 0;
                m_st[c] = 0; m_cnt[c] = 0; m_pin[c] = 0; m_presc[c] = 0;
                for (int g = 0; g < 4; g++) m_gr[c][g] = 0;
            end
        end else begin
            int blk, ofs, wd;
            blk = int'(bus_addr) >> 6;
            ofs = int'(bus_addr) & 63;
            wd  = int'(bus_wdata);
            for (int c = 0; c < NCH; c++) begin
                int run, dv, a, b, nc, setb, clrb;
                bit tk;
                run  = (m_start >> c) & 1;
                dv   = 1 << (2 * (m_ctrl[c] & 3));
                tk   = (run != 0) && (m_presc[c] >= dv - 1);
                m_presc[c] = (run == 0 || tk) ? 0 : m_presc[c] + 1;
                setb = 0;
                if (tk) begin
                    a = m_gr[c][0];
                    b = m_gr[c][1];
                    setb = ((m_cnt[c] == a) ? 1 : 0) | ((m_cnt[c] == b) ? 2 : 0);
                    nc = ((((m_ctrl[c] >> 6) & 1) != 0) && m_cnt[c] == b) ? 0 : ((m_cnt[c] + 1) & 16'hFFFF);
                    if ((m_mode[c] & 15) == 2 && (m_ioc[c] & 15) == 2)
                        m_pin[c] = (a < b && nc >= a && nc <= b) ? 1 : 0;
                    m_cnt[c] = nc;
                end
                clrb = (bus_we && blk == c + 1 && ofs == 'h10) ? (wd & 3) : 0;
                m_st[c] = (m_st[c] & ~clrb) | setb;
            end
            if (bus_we) begin
                if (blk == 0 && ofs == 0) m_start = wd & 3;
                else if (blk >= 1 && blk <= NCH) begin
                    case (ofs)
                        'h00: m_ctrl[blk-1] = wd;
                        'h04: m_mode[blk-1] = wd;
                        'h08: m_ioc[blk-1]  = wd;
                        'h0C: m_ien[blk-1]  = wd;
                        'h14: m_cnt[blk-1]  = wd;
                        'h18: m_gr[blk-1][0] = wd;
                        'h1C: m_gr[blk-1][1] = wd;
                        'h20: m_gr[blk-1][2] = wd;
                        'h24: m_gr[blk-1][3] = wd;
                        default: ;
                    endcase
                end
            end
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock pin comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < NCH; c++)
                check(int'(pwm_out[c]) == m_pin[c], cur_req, int'(pwm_out[c]), m_pin[c]);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int v, v2, p;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h54, v); check(v == 0, "R1", v, 0);
        rd(8'h00, v); check(v == 0, "R1", v, 0);
        rd(8'h50, v); check(v == 0, "R1", v, 0);
        check(pwm_out == 2'b00, "R1", int'(pwm_out), 0);

        // R10 readback and unmapped
        cur_req = "R10";
        wr(8'h58, 16'd3); wr(8'h5C, 16'd9);
        wr(8'h60, 16'h1234); wr(8'h64, 16'hBEEF); wr(8'h4C, 16'h0005);
        rd(8'h58, v); check(v == 3, "R10", v, 3);
        rd(8'h5C, v); check(v == 9, "R10", v, 9);
        rd(8'h60, v); check(v == 'h1234, "R10", v, 'h1234);
        rd(8'h64, v); check(v == 'hBEEF, "R10", v, 'hBEEF);
        rd(8'h4C, v); check(v == 5, "R10", v, 5);
        rd(8'h68, v); check(v == 0, "R10", v, 0);
        rd(8'hC0, v); check(v == 0, "R10", v, 0);
        rd(8'h04, v); check(v == 0, "R10", v, 0);

        // R5 PWM with A=3, B=9, divide 1
        cur_req = "R5";
        wr(8'h40, 16'h0040); wr(8'h44, 16'h0002); wr(8'h48, 16'h0002);
        wr(8'h00, 16'h0001);
        rd(8'h00, v); check(v == 1, "R2", v, 1);
        idle(40);
        rd(8'h54, v); check(v == m_cnt[0], "R4", v, m_cnt[0]);
        check(v <= 9, "R4", v, 9);

        // R8 status flags
        rd(8'h50, v); check(v == 3, "R8", v, 3);
        cur_req = "R7";
        wr(8'h00, 16'h0000);
        wr(8'h50, 16'h0001);
        rd(8'h50, v); check(v == 2, "R8", v, 2);
        check(v == m_st[0], "R8", v, m_st[0]);

        // R7 stopped channel holds
        rd(8'h54, v); idle(20); rd(8'h54, v2);
        check(v == v2, "R7", v2, v);
        p = int'(pwm_out[0]);
        wr(8'h58, 16'd5);
        rd(8'h58, v); check(v == 5, "R7", v, 5);
        check(int'(pwm_out[0]) == p, "R7", int'(pwm_out[0]), p);

        // R3 prescale divide 4 and 16
        cur_req = "R3";
        wr(8'h54, 16'd0); wr(8'h58, 16'd1); wr(8'h5C, 16'd4);
        wr(8'h40, 16'h0041);
        wr(8'h00, 16'h0001);
        rd(8'h54, v); check(v == 0, "R3", v, 0);
        idle(30);
        rd(8'h54, v); check(v == m_cnt[0], "R3", v, m_cnt[0]);
        wr(8'h40, 16'h0042);
        idle(200);
        rd(8'h54, v); check(v == m_cnt[0], "R3", v, m_cnt[0]);

        // R6 A=0 always high, A>=B always low
        cur_req = "R6";
        wr(8'h40, 16'h0040); wr(8'h5C, 16'd7); wr(8'h58, 16'd0);
        idle(30);
        check(pwm_out[0] == 1'b1, "R6", int'(pwm_out[0]), 1);
        wr(8'h58, 16'd8);
        idle(30);
        check(pwm_out[0] == 1'b0, "R6", int'(pwm_out[0]), 0);
        wr(8'h58, 16'd7);
        idle(30);
        check(pwm_out[0] == 1'b0, "R6", int'(pwm_out[0]), 0);

        // R9 compare change mid-run at divide 64
        cur_req = "R9";
        wr(8'h40, 16'h0043); wr(8'h58, 16'd2); wr(8'h5C, 16'd5);
        idle(300);
        wr(8'h5C, 16'd3);
        idle(400);
        rd(8'h54, v); check(v == m_cnt[0], "R9", v, m_cnt[0]);

        // R4 wrap without clear
        cur_req = "R4";
        wr(8'h00, 16'h0000);
        wr(8'h40, 16'h0000); wr(8'h58, 16'd1); wr(8'h5C, 16'd4);
        wr(8'h54, 16'hFFFD);
        wr(8'h00, 16'h0001);
        idle(6);
        rd(8'h54, v); check(v == m_cnt[0], "R4", v, m_cnt[0]);
        check(v < 16, "R4", v, 16);

        // R11 non-PWM mode holds pin
        cur_req = "R11";
        wr(8'h40, 16'h0040); wr(8'h58, 16'd2); wr(8'h5C, 16'd6);
        idle(5);
        wr(8'h44, 16'h0000);
        p = int'(pwm_out[0]);
        rd(8'h54, v);
        idle(25);
        rd(8'h54, v2);
        check(int'(pwm_out[0]) == p, "R11", int'(pwm_out[0]), p);
        check(v2 != v, "R11", v2, v);

        // R2 channel 1 independent
        cur_req = "R2";
        wr(8'h98, 16'd1); wr(8'h9C, 16'd3); wr(8'h80, 16'h0040);
        wr(8'h84, 16'h0002); wr(8'h88, 16'h0002);
        wr(8'h00, 16'h0002);
        rd(8'h00, v); check(v == 2, "R2", v, 2);
        rd(8'h54, v); idle(10); rd(8'h54, v2);
        check(v == v2, "R2", v2, v);
        rd(8'h94, v); check(v == m_cnt[1], "R2", v, m_cnt[1]);
        idle(20);

        summary();
        $finish;
    end
endmodule